// File: doc/BRIEF.md
# Stop-Mode Wake-Up Countdown Timer

This block is a 16-bit down-counter that advances on a slow, always-on tick (nominally 8 kHz) rather than on the main clock's activity. Because that tick keeps coming while the rest of the system is stopped, the timer can end a stop period after a chosen number of slow ticks. When the count runs out, the timer raises a sticky interrupt flag and raises a wake-up request while stop mode is active.

Software first writes the interval through the register write port with `wr_sel` = 0. It then writes the control word with `wr_sel` = 1 and bit 0 set, which loads the interval into the counter and starts it. Writing the control word with bit 0 clear halts the countdown and holds the count. The `tick` input is a one-clock pulse per slow ring cycle, already synchronised to `clk`. Any number of `tick` pulses may arrive in consecutive clocks.

Top module: `wake_timer`

## Requirements
- R1: A write with `wr_sel` = 0 stores `wr_data` as the interval and does not start the timer. `running` stays 0 and `count` does not change.
- R2: A write with `wr_sel` = 1 and `wr_data[0]` = 1 loads `count` from the stored interval and sets `running`, both visible after that clock edge. The load takes place whether or not the timer is already running.
- R3: While `running` is 1, each clock with `tick` high lowers `count` by one. A clock with `tick` low leaves `count` unchanged.
- R4: With an interval N of 1 or more, `irq` rises in the clock after the Nth tick following the start. At that point `running` is 0 and `count` is 0. This holds up to N = 65535.
- R5: With an interval of 0, `irq` rises on the first tick after the start.
- R6: A write with `wr_sel` = 1 and `wr_data[0]` = 0 clears `running` and holds `count`. Ticks have no effect while the timer is halted. A later start reloads the count from the interval.
- R7: `irq` stays set until a clock with `flag_clr` high clears it. When a flag-setting tick and `flag_clr` occur in the same clock, the flag ends up set.
- R8: `wake_req` is 1 exactly when `irq` is 1 and `stop_mode` is 1.
- R9: `stop_mode` has no effect on counting or on when `irq` rises.
- R10: After reset, `count` is 0, `running` is 0, `irq` is 0, `wake_req` is 0, and the stored interval is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 for the interval, 1 for the control word |
| wr_data | input | CNT_W | Write data. For the control word, bit 0 is the enable bit |
| tick | input | 1 | One-clock pulse per slow ring cycle |
| stop_mode | input | 1 | High while the system is in stop mode |
| flag_clr | input | 1 | Clears the interrupt flag |
| count | output | CNT_W | Current count value |
| running | output | 1 | Timer is counting |
| irq | output | 1 | Sticky zero-reached interrupt flag |
| wake_req | output | 1 | Wake-up request during stop mode |

## Verification
The embedded properties check the following relations on every cycle:
- The count drops by exactly one per tick and holds between ticks.
- The count is frozen while the timer is halted.
- A start loads the stored interval.
- The flag stays set until it is cleared.
- When the flag rises, the timer has stopped and the count is zero.
- A wake request appears only during stop mode.

Some properties depend on a whole sequence and can only be shown by the bench's scenarios:
- The total number of ticks to the interrupt for each interval, including 0, 1 and the 65535 maximum.
- That a re-enable after a halt reloads the interval.
- That stop mode leaves the tick count unchanged.
- That a simultaneous clear loses to a new flag.

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  input  logic             stop_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             irq,
  output logic             wake_req
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] interval_q, count_q;
  logic             run_q, flag_q;

  wire ivl_wr = wr_en & ~wr_sel;
  wire ctl_wr = wr_en & wr_sel;
  wire start  = ctl_wr & wr_data[0];
  wire halt   = ctl_wr & ~wr_data[0];
  wire step   = run_q & tick & ~ctl_wr;
  wire last   = step & (count_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      interval_q <= '0;
    else if (ivl_wr) interval_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (start) count_q <= interval_q;
    else if (last)  count_q <= '0;
    else if (step)  count_q <= count_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             run_q <= 1'b0;
    else if (start)         run_q <= 1'b1;
    else if (halt || last)  run_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (last)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign count    = count_q;
  assign running  = run_q;
  assign irq      = flag_q;
  assign wake_req = flag_q & stop_mode;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && count_q == $past(interval_q)));

  // R3
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q > ONE) |=> (count_q == $past(count_q) - ONE));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !ctl_wr) |=> $stable(count_q));

  // R6
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctl_wr) |=> $stable(count_q));

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (!run_q && count_q == '0));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R8
  wake_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (stop_mode && irq));

endmodule

// File: tb/tb_wake_timer.sv
module tb_wake_timer;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, tick = 1'b0, stop_mode = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic running, irq, wake_req;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wake_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .stop_mode(stop_mode), .flag_clr(flag_clr),
    .count(count), .running(running), .irq(irq), .wake_req(wake_req)
  );

  localparam int NV = 5;
  localparam logic [W-1:0] VEC_IVL [NV] = '{16'd1, 16'd2, 16'd5, 16'd100, 16'd0};
  localparam int           VEC_TCK [NV] = '{1, 2, 5, 100, 1};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n, input bit back_to_back);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
      if (!back_to_back) begin
        tick = 1'b0;
        cyc();
      end
    end
    tick = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); cyc();
    // R10
    chk(count == 0 && !running && !irq && !wake_req, "R10 reset state", {count, running, irq, wake_req}, 0);
    rst_n = 1'b1; cyc();

    // R1: interval write alone starts nothing
    wr(1'b0, 16'd7);
    ticks(3, 1'b0);
    chk(!running && count == 0, "R1 interval write does not start", {running, count}, 0);
    // R10: stored interval was 0 after reset, now 7
    wr(1'b1, 16'd1);
    chk(count == 7 && running, "R2 start loads interval", count, 7);
    wr(1'b1, 16'd0);

    // vector table walk: R4 and R5
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VEC_IVL[v]);
      wr(1'b1, 16'd1);
      ticks(VEC_TCK[v] - 1, 1'b0);
      chk(!irq, $sformatf("R4 no early flag ivl=%0d", VEC_IVL[v]), irq, 0);
      ticks(1, 1'b0);
      chk(irq && !running && count == 0,
          $sformatf("%s flag after %0d ticks", (VEC_IVL[v] == 0) ? "R5" : "R4", VEC_TCK[v]),
          {irq, running, count}, {1'b1, 1'b0, 16'd0});
      clear_flag();
      chk(!irq, "R7 flag cleared", irq, 0);
    end

    // R3: decrement per tick, hold without tick
    wr(1'b0, 16'd20);
    wr(1'b1, 16'd1);
    ticks(4, 1'b0);
    chk(count == 16, "R3 four ticks", count, 16);
    repeat (5) cyc();
    chk(count == 16 && running, "R3 idle hold", count, 16);

    // R6: halt holds, ticks ignored, restart reloads
    wr(1'b1, 16'd0);
    ticks(6, 1'b0);
    chk(count == 16 && !running, "R6 halted hold", count, 16);
    wr(1'b1, 16'd1);
    chk(count == 20 && running, "R6 restart reloads", count, 20);

    // R9: stop mode does not alter counting
    stop_mode = 1'b1;
    ticks(19, 1'b0);
    chk(count == 1 && !irq, "R9 count during stop", count, 1);
    ticks(1, 1'b0);
    chk(irq, "R9 flag during stop", irq, 1);
    // R8
    chk(wake_req, "R8 wake during stop", wake_req, 1);
    stop_mode = 1'b0; cyc();
    chk(!wake_req && irq, "R8 no wake outside stop", wake_req, 0);
    stop_mode = 1'b1; cyc();
    clear_flag();
    chk(!wake_req && !irq, "R8 wake drops with clear", wake_req, 0);
    stop_mode = 1'b0;

    // R7: set wins over simultaneous clear; sticky without clear
    wr(1'b0, 16'd1);
    wr(1'b1, 16'd1);
    tick = 1'b1; flag_clr = 1'b1;
    cyc();
    tick = 1'b0; flag_clr = 1'b0;
    chk(irq, "R7 set beats clear", irq, 1);
    repeat (10) cyc();
    chk(irq, "R7 sticky", irq, 1);
    clear_flag();

    // R4: maximum interval with back-to-back ticks
    wr(1'b0, 16'hFFFF);
    wr(1'b1, 16'd1);
    ticks(65534, 1'b1);
    chk(count == 1 && !irq && running, "R4 max interval before last", count, 1);
    ticks(1, 1'b1);
    chk(irq && !running && count == 0, "R4 max interval flag", {irq, running, count}, {1'b1, 1'b0, 16'd0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule